// File: doc/BRIEF.md
# Multi-Slot Endpoint Packet Buffer

This block stores packets for one data endpoint in a shared byte RAM split into 512-byte slots. A run-time depth code picks how many of the slots are in use: two, three or four. A bus-side producer writes one packet at a time into the next free slot. Meanwhile an external-logic consumer reads earlier committed packets out of other slots. The two sides never wait on each other while a free slot and a committed slot both exist.

Each committed packet keeps its own byte count. That count is clipped to the usable packet size: the configured maximum, at most one slot, and 64 bytes in full-speed mode. Packet data always starts at offset 0 of its slot.

A processor-style read window exposes only the head slot. The head slot is the oldest committed packet. The window is one slot wide and cannot reach any other slot.

A new depth code is held as pending and takes effect only on an endpoint reset. An endpoint reset also empties every slot.

Top module: `ep_pkt_buffer`

## Requirements
- R1: After `rst_n` is released, the active depth code is 2'b10 (two slots), `slot_full` is all zero, `wait_ext` is 1, `nak` is 0 and `cfg_err` is 0.
- R2: The active depth code maps to a slot count as follows: 2'b10 gives 2 slots, 2'b11 gives 3 slots and 2'b00 gives 4 slots. `nak` rises after exactly that many packets are committed with none consumed. The active code is never 2'b01.
- R3: A configuration write of code 2'b01 is rejected. The pending and active codes keep their previous values. `cfg_err` is set on the next clock edge and stays at 1 until `rst_n`.
- R4: A configuration write changes only the pending code. `act_code` takes the pending code only on the clock edge where `ep_reset` is high. That same edge clears every slot and both round-robin pointers to slot 0.
- R5: Slots are used in strict round-robin order 0, 1, …, N-1, 0. Committing a packet into slot i sets bit i of `slot_full`. The consumer drains the oldest packet first, and finishing it clears that slot's bit.
- R6: Each commit records a byte count: the number of accepted bytes, at most the packet limit. The consumer receives exactly that many bytes in write order. `cons_last` marks the final byte. A one-byte packet is valid.
- R7: The packet limit is `max_pkt` clipped to 512. A `max_pkt` of 0 counts as 512. When `full_speed` is 1 the limit is 64. Bytes past the limit are dropped, and the packet still commits on `prod_last`.
- R8: `nak` is 1 exactly when every active slot holds a committed packet. Producer bytes offered while `nak` is 1 are ignored.
- R9: `wait_ext` is 1 exactly when no slot holds a committed packet. A `cons_rd` while `wait_ext` is 1 is ignored and produces no `cons_vld`.
- R10: The producer can fill one slot while the consumer drains a different slot in the same cycles. Neither stream is corrupted by the other.
- R11: A `cpu_rd` at 9-bit offset `cpu_addr` returns the byte at that offset of the head slot on `cpu_rdata` one cycle later. After the head packet is drained, the same offset reads the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ep_reset | input | 1 | Endpoint reset: applies the pending depth and empties all slots |
| cfg_wr | input | 1 | Write strobe for the depth code |
| cfg_code | input | 2 | Depth code: 10 = 2 slots, 11 = 3 slots, 00 = 4 slots, 01 = invalid |
| max_pkt | input | 10 | Configured maximum packet size in bytes |
| full_speed | input | 1 | Limits packets to 64 bytes |
| prod_valid | input | 1 | Producer byte valid |
| prod_data | input | 8 | Producer byte |
| prod_last | input | 1 | Last byte of the packet; commits the slot |
| cons_rd | input | 1 | Consumer read request for one byte |
| cons_data | output | 8 | Consumer byte, one cycle after `cons_rd` |
| cons_vld | output | 1 | `cons_data` holds a byte |
| cons_last | output | 1 | `cons_data` is the final byte of the packet |
| cpu_rd | input | 1 | Window read strobe |
| cpu_addr | input | 9 | Byte offset inside the head slot |
| cpu_rdata | output | 8 | Window read data, one cycle after `cpu_rd` |
| slot_full | output | 4 | Bit per slot: committed packet present |
| act_slot | output | 2 | Index of the head slot shown in the window |
| nak | output | 1 | No free slot for the producer |
| wait_ext | output | 1 | No committed packet for the consumer |
| act_code | output | 2 | Depth code in effect |
| cfg_err | output | 1 | Sticky flag for an invalid depth code write |

## Verification
`slot_full`, `nak` and `wait_ext` change on the same clock edge that accepts the last byte of a packet, or the last consumer read of a packet. The bench therefore samples them on the falling edge right after that byte's strobe. `cons_data`, `cons_vld`, `cons_last` and `cpu_rdata` are registered one stage behind their request. Each read is issued as a one-cycle pulse and checked on the next falling edge. `cfg_err` and `act_code` settle one edge after `cfg_wr` or `ep_reset`, and they are sampled after that edge. Expected bytes come from a seed-and-index formula, and expected lengths come from the clip rule.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
  localparam int SLOT_BYTES_DEF = 512;
  localparam int FS_BYTES_DEF   = 64;
  localparam int MAX_SLOTS_DEF  = 4;

  // depth code to number of slots; 01 is never accepted
  function automatic int slots_of_code(input logic [1:0] code);
    case (code)
      2'b10:   return 2;
      2'b11:   return 3;
      2'b00:   return 4;
      default: return 2;
    endcase
  endfunction

  function automatic bit code_ok(input logic [1:0] code);
    return code != 2'b01;
  endfunction

  // usable bytes per packet
  function automatic int pkt_limit(input int max_pkt, input bit fs,
                                   input int slot_bytes, input int fs_bytes);
    int lim;
    lim = (max_pkt == 0 || max_pkt > slot_bytes) ? slot_bytes : max_pkt;
    if (fs && lim > fs_bytes) lim = fs_bytes;
    return lim;
  endfunction
endpackage

// File: rtl/ep_buf_cfg.sv
module ep_buf_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ep_reset,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_code,
  output logic [1:0] act_code,
  output logic       cfg_err
);
  import ep_buf_pkg::*;

  logic [1:0] pend_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code <= 2'b10;
      act_code  <= 2'b10;
      cfg_err   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        if (code_ok(cfg_code)) pend_code <= cfg_code;
        else                   cfg_err   <= 1'b1;
      end
      if (ep_reset) act_code <= pend_code;
    end
  end
endmodule

// File: rtl/ep_slot_tracker.sv
module ep_slot_tracker #(
  parameter int MAX_SLOTS = 4,
  parameter int CNT_W     = 10,
  parameter int OFF_W     = 9,
  localparam int SEL_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ep_reset,
  input  logic [SEL_W:0]       nslots,
  input  logic [CNT_W-1:0]     lim,
  input  logic                 prod_valid,
  input  logic                 prod_last,
  input  logic                 cons_rd,
  output logic [SEL_W-1:0]     wr_slot,
  output logic [OFF_W-1:0]     wr_ofs,
  output logic                 wr_en,
  output logic [SEL_W-1:0]     rd_slot,
  output logic [OFF_W-1:0]     rd_ofs,
  output logic                 rd_en,
  output logic                 rd_last,
  output logic                 commit_evt,
  output logic                 release_evt,
  output logic [CNT_W-1:0]     commit_cnt,
  output logic [MAX_SLOTS-1:0] slot_full,
  output logic                 nak,
  output logic                 wait_ext
);
  logic [CNT_W-1:0] wr_off, rd_off;
  logic [CNT_W-1:0] cnt_q [MAX_SLOTS];
  logic [SEL_W:0]   occ;
  logic             accept;

  function automatic logic [SEL_W-1:0] step(input logic [SEL_W-1:0] p,
                                            input logic [SEL_W:0] n);
    if (({1'b0, p} + (SEL_W+1)'(1)) >= n) return '0;
    return p + SEL_W'(1);
  endfunction

  assign nak         = (occ == nslots);
  assign wait_ext    = (occ == '0);
  assign accept      = prod_valid & ~nak;
  assign wr_en       = accept & (wr_off < lim);
  assign commit_evt  = accept & prod_last;
  assign commit_cnt  = wr_off + CNT_W'(wr_en);
  assign rd_en       = cons_rd & ~wait_ext;
  assign rd_last     = ((rd_off + CNT_W'(1)) == cnt_q[rd_slot]);
  assign release_evt = rd_en & rd_last;
  assign wr_ofs      = wr_off[OFF_W-1:0];
  assign rd_ofs      = rd_off[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off    <= '0;
      rd_off    <= '0;
      wr_slot   <= '0;
      rd_slot   <= '0;
      occ       <= '0;
      slot_full <= '0;
      for (int i = 0; i < MAX_SLOTS; i++) cnt_q[i] <= '0;
    end else if (ep_reset) begin
      wr_off    <= '0;
      rd_off    <= '0;
      wr_slot   <= '0;
      rd_slot   <= '0;
      occ       <= '0;
      slot_full <= '0;
    end else begin
      if (commit_evt) begin
        cnt_q[wr_slot]     <= commit_cnt;
        slot_full[wr_slot] <= 1'b1;
        wr_slot            <= step(wr_slot, nslots);
        wr_off             <= '0;
      end else if (wr_en) begin
        wr_off <= wr_off + CNT_W'(1);
      end
      if (release_evt) begin
        slot_full[rd_slot] <= 1'b0;
        rd_slot            <= step(rd_slot, nslots);
        rd_off             <= '0;
      end else if (rd_en) begin
        rd_off <= rd_off + CNT_W'(1);
      end
      case ({commit_evt, release_evt})
        2'b10:   occ <= occ + (SEL_W+1)'(1);
        2'b01:   occ <= occ - (SEL_W+1)'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/ep_buf_ram.sv
module ep_buf_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_data,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (a_en)  a_data <= mem[a_addr];
    if (b_en)  b_data <= mem[b_addr];
  end
endmodule

// File: rtl/ep_pkt_buffer.sv
module ep_pkt_buffer #(
  parameter int SLOT_BYTES = ep_buf_pkg::SLOT_BYTES_DEF,
  parameter int FS_BYTES   = ep_buf_pkg::FS_BYTES_DEF,
  parameter int MAX_SLOTS  = ep_buf_pkg::MAX_SLOTS_DEF,
  parameter int DW         = 8,
  localparam int OFF_W     = $clog2(SLOT_BYTES),
  localparam int CNT_W     = OFF_W + 1,
  localparam int SEL_W     = $clog2(MAX_SLOTS),
  localparam int DEPTH     = SLOT_BYTES * MAX_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ep_reset,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_code,
  input  logic [CNT_W-1:0]     max_pkt,
  input  logic                 full_speed,
  input  logic                 prod_valid,
  input  logic [DW-1:0]        prod_data,
  input  logic                 prod_last,
  input  logic                 cons_rd,
  output logic [DW-1:0]        cons_data,
  output logic                 cons_vld,
  output logic                 cons_last,
  input  logic                 cpu_rd,
  input  logic [OFF_W-1:0]     cpu_addr,
  output logic [DW-1:0]        cpu_rdata,
  output logic [MAX_SLOTS-1:0] slot_full,
  output logic [SEL_W-1:0]     act_slot,
  output logic                 nak,
  output logic                 wait_ext,
  output logic [1:0]           act_code,
  output logic                 cfg_err
);
  import ep_buf_pkg::*;

  // internal events, named for the checker
  logic [SEL_W:0]   nslots;
  logic [CNT_W-1:0] lim;
  logic [SEL_W-1:0] wr_slot, rd_slot;
  logic [OFF_W-1:0] wr_ofs, rd_ofs;
  logic             wr_en, rd_en, rd_last;
  logic             commit_evt, release_evt;
  logic [CNT_W-1:0] commit_cnt;

  assign nslots   = (SEL_W+1)'(slots_of_code(act_code));
  assign lim      = CNT_W'(pkt_limit(int'(max_pkt), full_speed, SLOT_BYTES, FS_BYTES));
  assign act_slot = rd_slot;

  ep_buf_cfg cfg_i (
    .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .cfg_wr(cfg_wr),
    .cfg_code(cfg_code), .act_code(act_code), .cfg_err(cfg_err)
  );

  ep_slot_tracker #(.MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W), .OFF_W(OFF_W)) trk_i (
    .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .nslots(nslots), .lim(lim),
    .prod_valid(prod_valid), .prod_last(prod_last), .cons_rd(cons_rd),
    .wr_slot(wr_slot), .wr_ofs(wr_ofs), .wr_en(wr_en),
    .rd_slot(rd_slot), .rd_ofs(rd_ofs), .rd_en(rd_en), .rd_last(rd_last),
    .commit_evt(commit_evt), .release_evt(release_evt), .commit_cnt(commit_cnt),
    .slot_full(slot_full), .nak(nak), .wait_ext(wait_ext)
  );

  ep_buf_ram #(.DEPTH(DEPTH), .DW(DW)) ram_i (
    .clk(clk),
    .wr_en(wr_en), .wr_addr({wr_slot, wr_ofs}), .wr_data(prod_data),
    .a_en(rd_en), .a_addr({rd_slot, rd_ofs}), .a_data(cons_data),
    .b_en(cpu_rd), .b_addr({rd_slot, cpu_addr}), .b_data(cpu_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cons_vld  <= 1'b0;
      cons_last <= 1'b0;
    end else begin
      cons_vld  <= rd_en;
      cons_last <= rd_en & rd_last;
    end
  end
endmodule

// File: rtl/ep_pkt_buffer_chk.sv
module ep_pkt_buffer_chk #(
  parameter int MAX_SLOTS = 4,
  parameter int CNT_W     = 10,
  localparam int SEL_W    = $clog2(MAX_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ep_reset,
  input logic                 cfg_wr,
  input logic [1:0]           cfg_code,
  input logic [1:0]           act_code,
  input logic                 cfg_err,
  input logic [MAX_SLOTS-1:0] slot_full,
  input logic [SEL_W:0]       nslots,
  input logic                 nak,
  input logic                 wait_ext,
  input logic                 cons_rd,
  input logic                 cons_vld,
  input logic                 commit_evt,
  input logic [CNT_W-1:0]     commit_cnt,
  input logic [CNT_W-1:0]     lim
);
  assert_code_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_code != 2'b01);

  assert_bad_code_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_code == 2'b01) |=> cfg_err);

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_depth_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_reset |=> $stable(act_code));

  assert_reset_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ep_reset |=> (slot_full == '0));

  assert_cnt_in_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (commit_cnt != '0 && commit_cnt <= lim));

  assert_nak_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nak == ($countones(slot_full) == int'(nslots)));

  assert_wait_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ext == (slot_full == '0));

  assert_no_read_on_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_rd && wait_ext) |=> !cons_vld);
endmodule

bind ep_pkt_buffer ep_pkt_buffer_chk #(.MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .cfg_wr(cfg_wr),
  .cfg_code(cfg_code), .act_code(act_code), .cfg_err(cfg_err),
  .slot_full(slot_full), .nslots(nslots), .nak(nak), .wait_ext(wait_ext),
  .cons_rd(cons_rd), .cons_vld(cons_vld), .commit_evt(commit_evt),
  .commit_cnt(commit_cnt), .lim(lim)
);

// File: tb/ep_pkt_buffer_tb.sv
`timescale 1ns/1ps
module ep_pkt_buffer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ep_reset = 1'b0, cfg_wr = 1'b0;
  logic [1:0] cfg_code = 2'b10;
  logic [9:0] max_pkt = 10'd512;
  logic       full_speed = 1'b0;
  logic       prod_valid = 1'b0, prod_last = 1'b0;
  logic [7:0] prod_data = '0;
  logic       cons_rd = 1'b0;
  logic [7:0] cons_data;
  logic       cons_vld, cons_last;
  logic       cpu_rd = 1'b0;
  logic [8:0] cpu_addr = '0;
  logic [7:0] cpu_rdata;
  logic [3:0] slot_full;
  logic [1:0] act_slot;
  logic       nak, wait_ext;
  logic [1:0] act_code;
  logic       cfg_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ep_pkt_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .cfg_wr(cfg_wr),
    .cfg_code(cfg_code), .max_pkt(max_pkt), .full_speed(full_speed),
    .prod_valid(prod_valid), .prod_data(prod_data), .prod_last(prod_last),
    .cons_rd(cons_rd), .cons_data(cons_data), .cons_vld(cons_vld),
    .cons_last(cons_last), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_rdata(cpu_rdata), .slot_full(slot_full), .act_slot(act_slot),
    .nak(nak), .wait_ext(wait_ext), .act_code(act_code), .cfg_err(cfg_err)
  );

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 7 + i);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] code);
    @(negedge clk); cfg_wr = 1'b1; cfg_code = code;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic ep_rst();
    @(negedge clk); ep_reset = 1'b1;
    @(negedge clk); ep_reset = 1'b0;
  endtask

  task automatic send_pkt(int len, int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      prod_valid = 1'b1; prod_data = pat(seed, i); prod_last = (i == len - 1);
    end
    @(negedge clk); prod_valid = 1'b0; prod_last = 1'b0;
  endtask

  task automatic drain_pkt(int exp_len, int seed, string req);
    int bad = 0;
    int lastpos = -1;
    for (int i = 0; i < exp_len; i++) begin
      @(negedge clk); cons_rd = 1'b1;
      @(negedge clk); cons_rd = 1'b0;
      if (!cons_vld || cons_data != pat(seed, i)) bad++;
      if (cons_vld && cons_last && lastpos < 0) lastpos = i;
    end
    check(bad == 0, req, "bytes mismatching", bad, 0);
    check(lastpos == exp_len - 1, "R6", "cons_last position", lastpos, exp_len - 1);
  endtask

  task automatic cpu_read(int addr, logic [7:0] exp, string req);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = 9'(addr);
    @(negedge clk); cpu_rd = 1'b0;
    check(cpu_rdata == exp, req, "window byte", cpu_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(act_code == 2'b10, "R1", "act_code", act_code, 2);
    check(slot_full == 4'b0, "R1", "slot_full", slot_full, 0);
    check(wait_ext == 1'b1, "R1", "wait_ext", wait_ext, 1);
    check(nak == 1'b0, "R1", "nak", nak, 0);
    check(cfg_err == 1'b0, "R1", "cfg_err", cfg_err, 0);

    // R2 R5 R8 R9: sweep the three valid depth codes
    for (int c = 0; c < 3; c++) begin
      logic [1:0] code;
      int n;
      logic [3:0] all;
      code = (c == 0) ? 2'b10 : (c == 1) ? 2'b11 : 2'b00;
      n = c + 2;
      all = 4'((1 << n) - 1);
      cfg_write(code);
      ep_rst();
      check(act_code == code, "R4", "act_code after ep_reset", act_code, code);
      for (int k = 0; k < n; k++) begin
        send_pkt(10 + 3 * k, k + 1);
        check(slot_full == 4'((1 << (k + 1)) - 1), "R5", "slot_full fill order",
              slot_full, (1 << (k + 1)) - 1);
        check(nak == (k == n - 1), "R2", "nak vs depth", nak, int'(k == n - 1));
        check(wait_ext == 1'b0, "R9", "wait_ext with data", wait_ext, 0);
      end
      send_pkt(5, 99);  // offered while nak: R8 ignored
      check(slot_full == all, "R8", "slot_full after nak'd packet", slot_full, all);
      for (int k = 0; k < n; k++) begin
        drain_pkt(10 + 3 * k, k + 1, "R5");
        check(slot_full == (all & ~4'((1 << (k + 1)) - 1)), "R5", "slot_full drain order",
              slot_full, all & ~4'((1 << (k + 1)) - 1));
        check(nak == 1'b0, "R8", "nak after free slot", nak, 0);
      end
      check(wait_ext == 1'b1, "R9", "wait_ext when empty", wait_ext, 1);
      @(negedge clk); cons_rd = 1'b1;
      @(negedge clk); cons_rd = 1'b0;
      check(cons_vld == 1'b0, "R9", "cons_vld on read while empty", cons_vld, 0);
      // wrapped pointers: next packet lands in slot 0, then slot 1
      send_pkt(4, 40);
      check(slot_full == 4'b0001, "R5", "wrap to slot 0", slot_full, 1);
      drain_pkt(4, 40, "R5");
      send_pkt(4, 41);
      check(slot_full == 4'b0010, "R5", "next slot 1", slot_full, 2);
      drain_pkt(4, 41, "R5");
    end

    // R3 invalid code, R4 pending vs active
    cfg_write(2'b01);
    check(cfg_err == 1'b1, "R3", "cfg_err after code 01", cfg_err, 1);
    check(act_code == 2'b00, "R3", "act_code kept", act_code, 0);
    ep_rst();
    check(act_code == 2'b00, "R3", "pending kept after ep_reset", act_code, 0);
    cfg_write(2'b11);
    check(act_code == 2'b00, "R4", "act_code before ep_reset", act_code, 0);
    ep_rst();
    check(act_code == 2'b11, "R4", "act_code after ep_reset", act_code, 3);
    check(cfg_err == 1'b1, "R3", "cfg_err sticky", cfg_err, 1);

    // R7 truncation
    max_pkt = 10'd100;
    send_pkt(150, 5);
    drain_pkt(100, 5, "R7");
    max_pkt = 10'd512; full_speed = 1'b1;
    send_pkt(80, 6);
    drain_pkt(64, 6, "R7");
    full_speed = 1'b0; max_pkt = 10'd0;
    send_pkt(512, 7);
    cpu_read(0, pat(7, 0), "R11");
    cpu_read(511, pat(7, 511), "R11");
    drain_pkt(512, 7, "R7");
    max_pkt = 10'd512;
    send_pkt(1, 8);
    drain_pkt(1, 8, "R6");

    // R11 window follows the head slot
    send_pkt(20, 11);
    send_pkt(20, 12);
    cpu_read(3, pat(11, 3), "R11");
    drain_pkt(20, 11, "R6");
    cpu_read(3, pat(12, 3), "R11");
    drain_pkt(20, 12, "R6");

    // R10 concurrent produce and consume, quad depth
    cfg_write(2'b00);
    ep_rst();
    send_pkt(30, 20);
    send_pkt(30, 21);
    send_pkt(30, 22);
    fork
      send_pkt(40, 23);
      drain_pkt(30, 20, "R10");
    join
    check(slot_full == 4'b1110, "R10", "slot_full after overlap", slot_full, 14);
    check(nak == 1'b0, "R10", "nak after overlap", nak, 0);
    send_pkt(25, 24);
    check(nak == 1'b1, "R8", "nak at full quad", nak, 1);
    fork
      send_pkt(9, 98);  // refused while full
      drain_pkt(30, 21, "R10");
    join
    drain_pkt(30, 22, "R10");
    drain_pkt(40, 23, "R10");
    drain_pkt(25, 24, "R10");
    check(wait_ext == 1'b1, "R9", "empty after all drains", wait_ext, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule